// File: doc/BRIEF.md
# Four-bank cluster node port with interleaved bank select

This block connects a cluster of cache banks to one local port of a network router in a clustered non-uniform cache. Requests from the router carry a line address and a transaction tag. A few low-order bits of the set index, just above the line offset, pick which bank of the cluster owns the line. Those bits are then removed, and the rest of the address goes to that bank. Because every bank in the cluster shares this one field, neighbouring sets fall in different banks.

Each bank is a fixed-latency model that holds one request at a time. While a bank is busy, a new request aimed at it is held off through the ready signal. Requests aimed at other banks are still accepted. Banks that finish at about the same time compete for the single shared reply port toward the router. A round-robin arbiter grants the port. The granted bank then keeps it until the last flit of its reply has been taken. A parameter can select a fixed lowest-index priority instead.

Top module: `cluster_bank_port`

## Requirements
- R1: Out of reset, `rsp_valid` is low and `req_ready` is high for any address.
- R2: The target bank is `req_addr[OFFSET_W +: log2(NUM_BANKS)]`, which is bits 7:6 with the default parameters. The reply reports that bank on `rsp_bank`.
- R3: Every reply flit carries on `rsp_data` the request address with the bank-select bits removed: the bits above the select field are shifted down by the select width, and the line-offset bits stay in place. With the defaults this is `{addr[15:8], addr[5:0]}`.
- R4: `rsp_id` returns the tag that was given with the request.
- R5: A request whose bank is still busy sees `req_ready` low and is not taken. It produces no reply until it is accepted.
- R6: On an idle port, the first reply flit is valid `BANK_LAT + 1` clock edges after the edge that accepted the request.
- R7: Each reply is `REPLY_FLITS` flits long. `rsp_flit` counts 0 to `REPLY_FLITS-1`, the first flit shows 0, and `rsp_last` is high only on the final flit.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_id`, `rsp_bank` and `rsp_flit` hold their values.
- R9: Once a reply has its first flit taken, the port stays with that bank until its last flit is taken. Flits of different replies never interleave.
- R10: When several banks have replies waiting, the port is granted starting from the bank after the one that last completed a reply, wrapping around.
- R11: Requests to different idle banks are accepted on consecutive cycles, even while other banks are busy or the reply port is stalled.
- R12: A bank is busy from the accepting edge until the edge on which its last flit is taken. A waiting request to it is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present from the router local port |
| req_ready | output | 1 | Target bank can take the request |
| req_addr | input | ADDR_W | Line address of the request |
| req_id | input | ID_W | Transaction tag |
| rsp_valid | output | 1 | Reply flit present |
| rsp_ready | input | 1 | Router takes the reply flit |
| rsp_bank | output | log2(NUM_BANKS) | Bank that owns the port |
| rsp_id | output | ID_W | Tag of the reply |
| rsp_data | output | ADDR_W-log2(NUM_BANKS) | Bank-local address carried by the flit |
| rsp_flit | output | max(1,log2(REPLY_FLITS)) | Flit index within the reply |
| rsp_last | output | 1 | Final flit of the reply |

## Verification
The hardest state to reach from the ports is several banks waiting at once while the round-robin pointer sits at a position where rotating order and fixed priority would disagree. The bench reaches it this way. It holds the reply port stalled, sends to bank 2 first, and then sends to banks 0, 1 and 3 on back-to-back cycles. Bank 2 therefore takes the port alone, and the pointer moves to 3 while the others wait. The port is then released with an irregular ready pattern, so the hold and lock rules are exercised during the same contention.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   typedef enum logic [1:0] {
      BK_IDLE = 2'd0,
      BK_WAIT = 2'd1,
      BK_PEND = 2'd2
   } bank_state_e;
endpackage

// File: rtl/cbp_bank_model.sv
module cbp_bank_model
   import cbp_pkg::*;
#(
   parameter int LOC_W = 14,
   parameter int ID_W  = 4,
   parameter int LAT   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LOC_W-1:0] start_loc,
   input  logic [ID_W-1:0]  start_id,
   input  logic             done,
   output logic             busy,
   output logic             pending,
   output logic [LOC_W-1:0] loc_q,
   output logic [ID_W-1:0]  id_q
);
   localparam int CNT_W = $clog2(LAT + 1);

   bank_state_e      state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= BK_IDLE;
         cnt   <= '0;
         loc_q <= '0;
         id_q  <= '0;
      end else begin
         unique case (state)
            BK_IDLE: if (start) begin
               state <= BK_WAIT;
               cnt   <= CNT_W'(LAT - 1);
               loc_q <= start_loc;
               id_q  <= start_id;
            end
            BK_WAIT: if (cnt == '0) state <= BK_PEND;
                     else           cnt   <= cnt - CNT_W'(1);
            BK_PEND: if (done) state <= BK_IDLE;
            default: state <= BK_IDLE;
         endcase
      end
   end

   assign busy    = (state != BK_IDLE);
   assign pending = (state == BK_PEND);
endmodule

// File: rtl/cbp_arbiter.sv
module cbp_arbiter #(
   parameter int N      = 4,
   parameter bit RR_ARB = 1'b1,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] ptr,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);
   assign gnt_valid = |req;

   if (RR_ARB) begin : g_rr
      logic [IDX_W-1:0] cand;
      always_comb begin
         gnt_idx = ptr;
         cand    = '0;
         for (int k = N - 1; k >= 0; k--) begin
            cand = ptr + IDX_W'(k);
            if (req[cand]) gnt_idx = cand;
         end
      end
   end else begin : g_fixed
      logic [IDX_W-1:0] unused_ptr;
      assign unused_ptr = ptr;
      always_comb begin
         gnt_idx = '0;
         for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) gnt_idx = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/cluster_bank_port.sv
module cluster_bank_port #(
   parameter int NUM_BANKS   = 4,
   parameter int ADDR_W      = 16,
   parameter int OFFSET_W    = 6,
   parameter int ID_W        = 4,
   parameter int BANK_LAT    = 3,
   parameter int REPLY_FLITS = 2,
   parameter bit RR_ARB      = 1'b1,
   localparam int SEL_W  = $clog2(NUM_BANKS),
   localparam int LOC_W  = ADDR_W - SEL_W,
   localparam int FLIT_W = (REPLY_FLITS > 1) ? $clog2(REPLY_FLITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [SEL_W-1:0]  rsp_bank,
   output logic [ID_W-1:0]   rsp_id,
   output logic [LOC_W-1:0]  rsp_data,
   output logic [FLIT_W-1:0] rsp_flit,
   output logic              rsp_last
);
   if (NUM_BANKS < 2 || (1 << SEL_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (OFFSET_W < 0 || OFFSET_W + SEL_W >= ADDR_W) begin : g_bad_addr
      $error("select field must lie inside the address with index bits above it");
   end
   if (BANK_LAT < 1) begin : g_bad_lat
      $error("BANK_LAT must be at least 1");
   end
   if (REPLY_FLITS < 1) begin : g_bad_flits
      $error("REPLY_FLITS must be at least 1");
   end

   logic [SEL_W-1:0]     req_sel;
   logic [LOC_W-1:0]     req_loc;
   logic                 accept;
   logic [NUM_BANKS-1:0] bank_busy;
   logic [NUM_BANKS-1:0] bank_pend;
   logic [LOC_W-1:0]     loc_arr [NUM_BANKS];
   logic [ID_W-1:0]      id_arr  [NUM_BANKS];

   logic                 own_v;
   logic [SEL_W-1:0]     own_idx;
   logic [FLIT_W-1:0]    flit_q;
   logic [SEL_W-1:0]     rr_ptr;
   logic                 gnt_valid;
   logic [SEL_W-1:0]     gnt_idx;
   logic                 fin;

   assign req_sel = req_addr[OFFSET_W +: SEL_W];

   if (OFFSET_W == 0) begin : g_loc_nooff
      assign req_loc = req_addr[ADDR_W-1:SEL_W];
   end else begin : g_loc_off
      assign req_loc = {req_addr[ADDR_W-1:OFFSET_W+SEL_W], req_addr[OFFSET_W-1:0]};
   end

   assign req_ready = !bank_busy[req_sel];
   assign accept    = req_valid && req_ready;
   assign fin       = own_v && rsp_ready && rsp_last;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      cbp_bank_model #(
         .LOC_W (LOC_W),
         .ID_W  (ID_W),
         .LAT   (BANK_LAT)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (accept && (req_sel == SEL_W'(b))),
         .start_loc (req_loc),
         .start_id  (req_id),
         .done      (fin && (own_idx == SEL_W'(b))),
         .busy      (bank_busy[b]),
         .pending   (bank_pend[b]),
         .loc_q     (loc_arr[b]),
         .id_q      (id_arr[b])
      );
   end

   cbp_arbiter #(
      .N      (NUM_BANKS),
      .RR_ARB (RR_ARB)
   ) u_arb (
      .req       (bank_pend),
      .ptr       (rr_ptr),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_v   <= 1'b0;
         own_idx <= '0;
         flit_q  <= '0;
         rr_ptr  <= '0;
      end else if (!own_v) begin
         if (gnt_valid) begin
            own_v   <= 1'b1;
            own_idx <= gnt_idx;
            flit_q  <= '0;
         end
      end else if (rsp_ready) begin
         if (rsp_last) begin
            own_v  <= 1'b0;
            flit_q <= '0;
            rr_ptr <= own_idx + SEL_W'(1);
         end else begin
            flit_q <= flit_q + FLIT_W'(1);
         end
      end
   end

   assign rsp_valid = own_v;
   assign rsp_bank  = own_idx;
   assign rsp_data  = loc_arr[own_idx];
   assign rsp_id    = id_arr[own_idx];
   assign rsp_flit  = flit_q;
   assign rsp_last  = (flit_q == FLIT_W'(REPLY_FLITS - 1));
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
   parameter int NUM_BANKS   = 4,
   parameter int ADDR_W      = 16,
   parameter int OFFSET_W    = 6,
   parameter int ID_W        = 4,
   parameter int REPLY_FLITS = 2,
   localparam int SEL_W  = $clog2(NUM_BANKS),
   localparam int LOC_W  = ADDR_W - SEL_W,
   localparam int FLIT_W = (REPLY_FLITS > 1) ? $clog2(REPLY_FLITS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [SEL_W-1:0]  rsp_bank,
   input logic [ID_W-1:0]   rsp_id,
   input logic [LOC_W-1:0]  rsp_data,
   input logic [FLIT_W-1:0] rsp_flit,
   input logic              rsp_last
);
   logic [SEL_W-1:0] chk_sel;
   assign chk_sel = req_addr[OFFSET_W +: SEL_W];

   // R1: port idle when reset is released
   p_idle_out_of_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !rsp_valid);

   // R5: the bank just given a request cannot take another on the next cycle
   p_no_double_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         !(req_valid && req_ready && (chk_sel == $past(chk_sel))));

   // R7: a reply opens with flit index zero
   p_first_flit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (rsp_flit == '0));

   // R8: stalled flit holds
   p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_data) && $stable(rsp_id) &&
          $stable(rsp_bank) && $stable(rsp_flit)));

   // R9: the port stays with one bank until its last flit
   p_port_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready && !rsp_last) |=>
         (rsp_valid && $stable(rsp_bank) &&
          (rsp_flit == FLIT_W'($past(rsp_flit) + FLIT_W'(1)))));
endmodule

bind cluster_bank_port cbp_checker #(
   .NUM_BANKS   (NUM_BANKS),
   .ADDR_W      (ADDR_W),
   .OFFSET_W    (OFFSET_W),
   .ID_W        (ID_W),
   .REPLY_FLITS (REPLY_FLITS)
) u_cbp_checker (.*);

// File: tb/cluster_bank_port_tb.sv
module cluster_bank_port_tb;
   localparam int NB  = 4;
   localparam int AW  = 16;
   localparam int OW  = 6;
   localparam int IW  = 4;
   localparam int LAT = 3;
   localparam int FL  = 2;
   localparam int SW  = 2;
   localparam int LW  = AW - SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [IW-1:0] req_id = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [SW-1:0] rsp_bank;
   logic [IW-1:0] rsp_id;
   logic [LW-1:0] rsp_data;
   logic [0:0]    rsp_flit;
   logic          rsp_last;

   cluster_bank_port #(
      .NUM_BANKS(NB), .ADDR_W(AW), .OFFSET_W(OW), .ID_W(IW),
      .BANK_LAT(LAT), .REPLY_FLITS(FL), .RR_ARB(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_id(req_id), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_bank(rsp_bank), .rsp_id(rsp_id),
      .rsp_data(rsp_data), .rsp_flit(rsp_flit), .rsp_last(rsp_last)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc++;

   int exp_loc [NB];
   int exp_id  [NB];
   bit exp_valid [NB];
   int acc_cyc [NB];
   int done_cyc [NB];
   int order_log [64];
   int done_cnt = 0;
   int exp_flit = 0;
   int cur_bank = 0;
   bit in_reply = 0;
   bit lat_chk = 0;
   bit prev_stall = 0;
   int pd, pi, pb, pf;

   function automatic int bank_of(int a);
      return (a >> OW) & (NB - 1);
   endfunction
   function automatic int loc_of(int a);
      return ((a >> (OW + SW)) << OW) | (a & ((1 << OW) - 1));
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // reply monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            chk(rsp_valid && rsp_data == pd && rsp_id == pi && rsp_bank == pb
                && rsp_flit == pf, "R8", "stalled flit changed", int'(rsp_data), pd);
         if (rsp_valid) begin
            if (!in_reply) begin
               in_reply = 1;
               if (lat_chk)
                  chk(cyc - acc_cyc[rsp_bank] == LAT + 1, "R6", "first flit latency",
                      cyc - acc_cyc[rsp_bank], LAT + 1);
            end
            if (rsp_ready) begin
               chk(int'(rsp_flit) == exp_flit, "R7", "flit index", int'(rsp_flit), exp_flit);
               chk(rsp_last == (exp_flit == FL - 1), "R7", "last flag", int'(rsp_last),
                   int'(exp_flit == FL - 1));
               if (exp_flit == 0)
                  chk(exp_valid[rsp_bank], "R2", "reply from bank without request",
                      int'(rsp_bank), -1);
               else
                  chk(int'(rsp_bank) == cur_bank, "R9", "bank changed mid reply",
                      int'(rsp_bank), cur_bank);
               chk(int'(rsp_data) == exp_loc[rsp_bank], "R3", "bank-local address",
                   int'(rsp_data), exp_loc[rsp_bank]);
               chk(int'(rsp_id) == exp_id[rsp_bank], "R4", "reply tag",
                   int'(rsp_id), exp_id[rsp_bank]);
               cur_bank = rsp_bank;
               if (rsp_last) begin
                  order_log[done_cnt % 64] = rsp_bank;
                  done_cyc[rsp_bank] = cyc + 1;
                  exp_valid[rsp_bank] = 0;
                  done_cnt++;
                  exp_flit = 0;
                  in_reply = 0;
               end else begin
                  exp_flit++;
               end
            end
         end
         prev_stall = rsp_valid && !rsp_ready;
         pd = rsp_data; pi = rsp_id; pb = rsp_bank; pf = rsp_flit;
      end
   end

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // called at posedge+1; returns at posedge+1 after acceptance
   task automatic send(int addr, int id, output int waits);
      int b;
      req_valid = 1; req_addr = AW'(addr); req_id = IW'(id);
      waits = 0;
      @(negedge clk);
      while (!req_ready) begin waits++; @(negedge clk); end
      b = bank_of(addr);
      exp_loc[b] = loc_of(addr); exp_id[b] = id; exp_valid[b] = 1;
      acc_cyc[b] = cyc + 1;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wait_done(int target);
      while (done_cnt < target) idle(1);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   int uppers [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
   int lowers [4] = '{6'h00, 6'h3F, 6'h15, 6'h2A};

   initial begin
      int w;
      int a_done;
      int k;
      for (int b = 0; b < NB; b++) begin exp_valid[b] = 0; acc_cyc[b] = 0; done_cyc[b] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!rsp_valid, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      chk(req_ready, "R1", "req_ready in reset", int'(req_ready), 1);
      @(posedge clk); #1 rst_n = 1;
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R1", "state after reset", int'(rsp_valid), 0);
      idle(1);

      // R2 R3 R4 R6 R7: sweep banks and address patterns on an idle port
      lat_chk = 1;
      for (int b = 0; b < NB; b++) begin
         for (int p = 0; p < 4; p++) begin
            int addr;
            addr = (uppers[p] << 8) | (b << 6) | lowers[p];
            send(addr, (b * 4 + p) & 15, w);
            chk(w == 0, "R11", "idle bank refused", w, 0);
            wait_done(done_cnt + 1);
            chk(order_log[(done_cnt - 1) % 64] == b, "R2", "reply bank", order_log[(done_cnt - 1) % 64], b);
            idle(1);
         end
      end

      // R5 R12: second request to a busy bank is held off
      send(16'h1240 | 6'h07, 5, w);
      a_done = done_cnt;
      req_valid = 1; req_addr = 16'h7740 | 6'h11; req_id = 6;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!req_ready, "R5", "busy bank ready", int'(req_ready), 0);
      end
      while (!req_ready) @(negedge clk);
      chk(done_cnt == a_done + 1, "R5", "replies before second accept", done_cnt, a_done + 1);
      acc_cyc[1] = cyc + 1;
      chk(acc_cyc[1] == done_cyc[1] + 1, "R12", "accept edge after release",
          acc_cyc[1], done_cyc[1] + 1);
      exp_loc[1] = loc_of(16'h7751); exp_id[1] = 6; exp_valid[1] = 1;
      @(posedge clk); #1 req_valid = 0;
      wait_done(a_done + 2);
      idle(2);

      // R10 R11 R8: contention with a stalled, then irregular, reply port
      lat_chk = 0;
      rsp_ready = 0;
      begin
         int base;
         base = done_cnt;
         for (int b = 0; b < NB; b++) begin
            send((b * 16'h0900) | (b << 6) | 6'h0B, 8 + b, w);
            chk(w == 0, "R11", "back-to-back accept waited", w, 0);
         end
         idle(LAT + 3);
         k = 0;
         while (done_cnt < base + NB) begin rsp_ready = (k % 3 != 2); idle(1); k++; end
         rsp_ready = 1;
         for (int i = 0; i < NB; i++)
            chk(order_log[(base + i) % 64] == i, "R10", "grant order round 1",
                order_log[(base + i) % 64], i);
         idle(2);
         base = done_cnt;
         rsp_ready = 0;
         send(16'h5080 | 6'h01, 12, w);
         send(16'h6000 | 6'h02, 13, w);
         chk(w == 0, "R11", "accept while another bank busy", w, 0);
         send(16'h6140 | 6'h03, 14, w);
         send(16'h62C0 | 6'h04, 15, w);
         idle(LAT + 3);
         k = 0;
         while (done_cnt < base + NB) begin rsp_ready = (k % 4 < 2); idle(1); k++; end
         rsp_ready = 1;
         begin
            int expo [4] = '{2, 3, 0, 1};
            for (int i = 0; i < NB; i++)
               chk(order_log[(base + i) % 64] == expo[i], "R10", "grant order round 2",
                   order_log[(base + i) % 64], expo[i]);
         end
      end
      idle(4);
      chk(!rsp_valid, "R9", "port idle after all replies", int'(rsp_valid), 0);
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
         $finish;
      end
   end
endmodule